// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block runs external bus cycles for a small 8-bit core that uses a 16-bit address. The upper address byte goes out on dedicated pins. The lower address byte and the data byte share one set of bidirectional pins, separated in time by an address strobe. The pad ring owns the tri-state buffers, so every shared or releasable pin group is exposed as separate output, input and enable signals.

Each cycle has the same phases. In T1 the address goes out and the strobe is high. In T2 the read or write strobe is asserted and the ready input is sampled. Any wait states follow. In T3 read data is captured and the strobe is released. The core side is a valid/ready request channel. A request is accepted only when `req_valid` and `req_ready` are both high in the same cycle. `req_ready` is high only at a cycle boundary: when the controller is idle, or in T3 of the current cycle, which allows back-to-back cycles. The address and data fields must stay stable while `req_valid` is high and `req_ready` is low. Completion is a single-cycle `rsp_valid` pulse that carries the read byte. This response channel has no back-pressure, so the core must take the pulse.

An external master can claim the bus through a hold request. The controller also turns an asynchronous reset input into a reset output that is synchronous to the clock.

Top module: `mux_bus_ctrl`

## Requirements
- R1: During T1, T2, wait states and T3, `a_hi` carries address bits 15..8 of the accepted request, and `bus_oe` is 1 in every state except the bus-released state.
- R2: In T1, `ad_oe` is 1 and `ad_o` carries address bits 7..0.
- R3: `ale` is 1 for exactly one cycle per bus cycle, in T1, and is 0 in all other states.
- R4: `io_m` is 1 during an I/O cycle and 0 during a memory cycle or when idle. `stat` is 2'b10 for a read, 2'b01 for a write, 2'b11 for an opcode fetch and 2'b00 when no cycle runs.
- R5: For a read, `rd_n` is 0 from T2 through the last wait state and `ad_oe` stays 0 throughout. `ad_i` is captured at the end of T3, and `rsp_valid` pulses high in the following cycle with that byte on `rsp_rdata`. An opcode fetch is always a read, whatever `req_write` says.
- R6: For a write, `wr_n` is 0 from T2 through the last wait state, and `ad_o` carries the write byte with `ad_oe` high from T2 through T3. `rd_n` and `wr_n` are never low together. `rsp_valid` pulses high in the cycle after T3.
- R7: Each time `ready` is sampled low at the end of T2 or a wait state, one more wait state is inserted with the strobe held. The cycle moves to T3 after the first edge with `ready` high.
- R8: `hold` is examined only at a cycle boundary (idle or T3). A hold raised during T1 or T2 does not interrupt the running cycle. Once the bus is released, `hlda` is 1, `bus_oe` and `ad_oe` are 0, and `req_ready` is 0 until `hold` drops.
- R9: A low `rst_in_n` drives `rst_out` high without waiting for a clock edge. After `rst_in_n` rises, `rst_out` falls on the second rising clock edge. While `rst_out` is high the bus is idle and `req_ready` is 0.
- R10: `req_ready` is high in idle and in T3 when `hold` is low. A request accepted in T3 starts its T1 in the next cycle, in the same cycle as the previous cycle's `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_in_n | input | 1 | Asynchronous active-low reset input |
| rst_out | output | 1 | Synchronized active-high reset for peripherals |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_fetch | input | 1 | 1 = opcode fetch (read) |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Captured read byte |
| a_hi | output | 8 | Upper address pins (value) |
| bus_oe | output | 1 | Enable for upper address, strobes and io_m |
| ad_o | output | 8 | Shared address/data pins, outgoing value |
| ad_i | input | 8 | Shared address/data pins, incoming value |
| ad_oe | output | 1 | Enable for the shared pins |
| ale | output | 1 | Address strobe, high in T1 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| stat | output | 2 | Cycle status code |
| ready | input | 1 | External ready; low inserts wait states |
| hold | input | 1 | External bus request |
| hlda | output | 1 | Bus released acknowledge |

## Verification
The bench builds the controller with its default parameters: a 16-bit address, an 8-bit data path and a two-stage reset synchronizer. With these values a single test can check that the upper and lower address bytes separate at bit 8, and that reset release takes exactly two edges. The vector table drives memory and I/O reads and writes and opcode fetches, including one fetch with the write flag set, with zero to three wait states. This makes the strobe width depend on `ready`. Directed tests cover three further cases: a hold in idle, a hold raised in the middle of a cycle, and a request accepted in T3.

// File: rtl/mbc_pkg.sv
`timescale 1ns/1ps
package mbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_T2, ST_TW, ST_T3, ST_REL
  } bus_st_e;

  localparam logic [1:0] STAT_NONE  = 2'b00;
  localparam logic [1:0] STAT_WRITE = 2'b01;
  localparam logic [1:0] STAT_READ  = 2'b10;
  localparam logic [1:0] STAT_FETCH = 2'b11;
endpackage

// File: rtl/mbc_rst_sync.sv
`timescale 1ns/1ps
module mbc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_o
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_in_n) begin
      if (!rst_in_n) chain[g] <= 1'b0;
      else if (g == 0) chain[g] <= 1'b1;
      else chain[g] <= chain[(g == 0) ? 0 : g-1];
    end
  end

  assign rst_o = ~chain[STAGES-1];

  // R9
  rst_hold_low_chk: assert property (@(posedge clk) !rst_in_n |-> rst_o);
endmodule

// File: rtl/mbc_seq.sv
`timescale 1ns/1ps
module mbc_seq
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic              req_io,
  input  logic              req_fetch,
  input  logic              ready_i,
  input  logic              hold_i,
  input  logic [DATA_W-1:0] ad_i,
  output bus_st_e           state,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata,
  output logic              cur_write,
  output logic              cur_io,
  output logic              cur_fetch,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  bus_st_e nxt;
  logic    at_boundary;
  logic    take;

  assign at_boundary = (state == ST_IDLE) || (state == ST_T3);
  assign req_ready   = at_boundary && !hold_i && !rst;
  assign take        = req_valid && req_ready;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE, ST_T3: begin
        if (hold_i)         nxt = ST_REL;
        else if (req_valid) nxt = ST_T1;
        else                nxt = ST_IDLE;
      end
      ST_T1:        nxt = ST_T2;
      ST_T2, ST_TW: nxt = ready_i ? ST_T3 : ST_TW;
      ST_REL:       nxt = hold_i ? ST_REL : ST_IDLE;
      default:      nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_addr  <= '0;
      cur_wdata <= '0;
      cur_write <= 1'b0;
      cur_io    <= 1'b0;
      cur_fetch <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      state     <= nxt;
      rsp_valid <= (state == ST_T3);
      if (state == ST_T3 && !cur_write) rsp_rdata <= ad_i;
      if (take) begin
        cur_addr  <= req_addr;
        cur_wdata <= req_wdata;
        cur_write <= req_write && !req_fetch;
        cur_io    <= req_io;
        cur_fetch <= req_fetch;
      end
    end
  end

  // R7
  wait_insert_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_T2 || state == ST_TW) && !ready_i) |=> (state == ST_TW));
  // R10
  t1_from_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_T1) |-> ($past(state) == ST_IDLE || $past(state) == ST_T3));
  // R5
  done_after_t3_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(state) == ST_T3));
  // R8
  hold_no_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_T1 && hold_i) |=> (state == ST_T2));
endmodule

// File: rtl/mbc_pins.sv
`timescale 1ns/1ps
module mbc_pins
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_st_e           state,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] cur_wdata,
  input  logic              cur_write,
  input  logic              cur_io,
  input  logic              cur_fetch,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic              bus_oe,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic [1:0]        stat,
  output logic              hlda
);
  logic in_cycle, strobe, data_phase;

  assign in_cycle   = (state == ST_T1) || (state == ST_T2) ||
                      (state == ST_TW) || (state == ST_T3);
  assign strobe     = (state == ST_T2) || (state == ST_TW);
  assign data_phase = strobe || (state == ST_T3);

  always_comb begin
    a_hi   = in_cycle ? cur_addr[ADDR_W-1:DATA_W] : '0;
    bus_oe = (state != ST_REL);
    hlda   = (state == ST_REL);
    ale    = (state == ST_T1);
    rd_n   = !(strobe && !cur_write);
    wr_n   = !(strobe && cur_write);
    io_m   = in_cycle && cur_io;
    ad_oe  = (state == ST_T1) || (cur_write && data_phase);
    if (state == ST_T1)              ad_o = cur_addr[DATA_W-1:0];
    else if (cur_write && data_phase) ad_o = cur_wdata;
    else                             ad_o = '0;
    if (!in_cycle)      stat = STAT_NONE;
    else if (cur_fetch) stat = STAT_FETCH;
    else if (cur_write) stat = STAT_WRITE;
    else                stat = STAT_READ;
  end

  // R3
  ale_drives_addr_chk: assert property (@(posedge clk) disable iff (rst)
    ale |-> (ad_oe && bus_oe));
  // R5
  rd_no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe);
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> rd_n);
  // R8
  released_float_chk: assert property (@(posedge clk) disable iff (rst)
    hlda |-> (!bus_oe && !ad_oe));
endmodule

// File: rtl/mux_bus_ctrl.sv
`timescale 1ns/1ps
module mux_bus_ctrl
  import mbc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_in_n,
  output logic              rst_out,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic              req_io,
  input  logic              req_fetch,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic              bus_oe,
  output logic [DATA_W-1:0] ad_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic              ad_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic [1:0]        stat,
  input  logic              ready,
  input  logic              hold,
  output logic              hlda
);
  bus_st_e           state;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic              cur_write, cur_io, cur_fetch;

  mbc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_in_n(rst_in_n), .rst_o(rst_out)
  );

  mbc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst_out),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_write(req_write), .req_io(req_io), .req_fetch(req_fetch),
    .ready_i(ready), .hold_i(hold), .ad_i(ad_i),
    .state(state), .cur_addr(cur_addr), .cur_wdata(cur_wdata),
    .cur_write(cur_write), .cur_io(cur_io), .cur_fetch(cur_fetch),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  mbc_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst(rst_out), .state(state),
    .cur_addr(cur_addr), .cur_wdata(cur_wdata),
    .cur_write(cur_write), .cur_io(cur_io), .cur_fetch(cur_fetch),
    .a_hi(a_hi), .bus_oe(bus_oe), .ad_o(ad_o), .ad_oe(ad_oe),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m),
    .stat(stat), .hlda(hlda)
  );
endmodule

// File: tb/mux_bus_ctrl_test.sv
`timescale 1ns/1ps
module mux_bus_ctrl_test;
  typedef struct packed {
    logic        wr;
    logic        io;
    logic        fe;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [7:0]  rd;
    logic [2:0]  waits;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 16'h1234, 8'h00, 8'hA5, 3'd0},
    '{1'b1, 1'b0, 1'b0, 16'hBEEF, 8'h3C, 8'h00, 3'd0},
    '{1'b0, 1'b1, 1'b0, 16'h0047, 8'h00, 8'h5A, 3'd2},
    '{1'b1, 1'b1, 1'b0, 16'h0099, 8'hC3, 8'h00, 3'd1},
    '{1'b0, 1'b0, 1'b1, 16'hFFFF, 8'h00, 8'h7E, 3'd3},
    '{1'b1, 1'b0, 1'b1, 16'h0000, 8'h55, 8'h01, 3'd0}
  };

  logic clk = 1'b0;
  logic rst_in_n = 1'b0;
  logic rst_out, req_valid, req_ready, req_write, req_io, req_fetch;
  logic [15:0] req_addr;
  logic [7:0] req_wdata, rsp_rdata, ad_o, ad_i, a_hi;
  logic rsp_valid, bus_oe, ad_oe, ale, rd_n, wr_n, io_m, ready, hold, hlda;
  logic [1:0] stat;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mux_bus_ctrl uut (
    .clk(clk), .rst_in_n(rst_in_n), .rst_out(rst_out),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io),
    .req_fetch(req_fetch), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .a_hi(a_hi), .bus_oe(bus_oe), .ad_o(ad_o), .ad_i(ad_i), .ad_oe(ad_oe),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .stat(stat),
    .ready(ready), .hold(hold), .hlda(hlda)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic wr_eff;
    logic [1:0] exp_stat;
    wr_eff   = v.wr && !v.fe;
    exp_stat = v.fe ? 2'b11 : (wr_eff ? 2'b01 : 2'b10);
    @(negedge clk);
    req_valid = 1'b1; req_addr = v.addr; req_wdata = v.wd;
    req_write = v.wr; req_io = v.io; req_fetch = v.fe; ready = 1'b1;
    chk("R10 ready in idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0; ready = (v.waits == 0);
    chk("R3 ale in T1", ale, 1);
    chk("R2 ad_oe in T1", ad_oe, 1);
    chk("R2 low address", ad_o, v.addr[7:0]);
    chk("R1 high address", a_hi, v.addr[15:8]);
    chk("R4 status", stat, exp_stat);
    chk("R4 io_m", io_m, v.io);
    @(negedge clk);
    ad_i = v.rd;
    chk("R3 ale low in T2", ale, 0);
    chk("R5 R6 strobes in T2", {rd_n, wr_n}, wr_eff ? 2'b10 : 2'b01);
    chk("R5 R6 ad_oe in T2", ad_oe, wr_eff);
    if (wr_eff) chk("R6 write data", ad_o, v.wd);
    chk("R1 high address held", a_hi, v.addr[15:8]);
    for (int i = 1; i <= int'(v.waits); i++) begin
      @(negedge clk);
      ready = (i == int'(v.waits));
      chk("R7 strobe held in wait", {rd_n, wr_n}, wr_eff ? 2'b10 : 2'b01);
    end
    @(negedge clk);
    chk("R5 strobes released in T3", {rd_n, wr_n}, 2'b11);
    chk("R6 ad_oe in T3", ad_oe, wr_eff);
    chk("R5 no done in T3", rsp_valid, 0);
    @(negedge clk);
    ad_i = 8'h00;
    chk("R5 R6 done pulse", rsp_valid, 1);
    if (!wr_eff) chk("R5 read data", rsp_rdata, v.rd);
    chk("R4 idle status", stat, 2'b00);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    req_valid = 0; req_addr = 0; req_wdata = 0; req_write = 0;
    req_io = 0; req_fetch = 0; ad_i = 0; ready = 1; hold = 0;
    repeat (3) @(negedge clk);
    chk("R9 rst_out in reset", rst_out, 1);
    chk("R9 no ready in reset", req_ready, 0);
    chk("R9 idle strobes", {ale, rd_n, wr_n, hlda}, 4'b0110);
    chk("R4 R9 idle status", stat, 2'b00);
    rst_in_n = 1'b1;
    @(negedge clk);
    chk("R9 rst_out after one edge", rst_out, 1);
    @(negedge clk);
    chk("R9 rst_out after two edges", rst_out, 0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R8 hold while idle
    @(negedge clk);
    hold = 1; req_valid = 1; req_addr = 16'h4321; req_write = 0; req_io = 0; req_fetch = 0;
    @(negedge clk);
    chk("R8 hlda", hlda, 1);
    chk("R8 bus released", {bus_oe, ad_oe}, 2'b00);
    chk("R8 no accept in hold", req_ready, 0);
    @(negedge clk);
    chk("R8 no cycle in hold", ale, 0);
    hold = 0;
    @(negedge clk);
    chk("R8 hlda dropped", hlda, 0);
    chk("R8 ready after hold", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    chk("R8 pending request starts", {ale, ad_o}, {1'b1, 8'h21});
    repeat (3) @(negedge clk);

    // R8 hold raised mid-cycle
    req_valid = 1; req_addr = 16'h0102; req_write = 0;
    @(negedge clk);
    req_valid = 0; hold = 1;
    @(negedge clk);
    chk("R8 cycle continues", {hlda, bus_oe, rd_n}, 3'b010);
    @(negedge clk);
    chk("R8 still owns bus in T3", hlda, 0);
    @(negedge clk);
    chk("R8 released after T3", {hlda, bus_oe, ad_oe}, 3'b100);
    chk("R8 done still reported", rsp_valid, 1);
    hold = 0;
    @(negedge clk);
    chk("R8 bus back", {hlda, bus_oe}, 2'b01);

    // R10 back-to-back
    req_valid = 1; req_addr = 16'hA0B0; req_wdata = 8'h11; req_write = 1;
    @(negedge clk);
    @(negedge clk);
    req_addr = 16'hC0D0; req_write = 0;
    @(negedge clk);
    chk("R10 ready in T3", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    chk("R10 next T1 immediate", {ale, ad_o}, {1'b1, 8'hD0});
    chk("R10 done overlaps T1", rsp_valid, 1);
    repeat (3) @(negedge clk);

    // R9 asynchronous assertion
    #1 rst_in_n = 0;
    #0.5;
    chk("R9 async assert", rst_out, 1);
    @(negedge clk);
    rst_in_n = 1;
    repeat (3) @(negedge clk);
    chk("R9 released again", rst_out, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule